// File: doc/BRIEF.md
# Serial Link Deskew and Word Aligner

This block calibrates the receive side of a source-synchronous serial link at startup. The receiver forwards its own clock to the far end. The data that comes back therefore arrives with an unknown phase relative to the local sampling clock. The controller fixes this in two stages. First it moves a programmable input delay and decides which settings give a stable sampled word stream. Then it moves the deserializer's word boundary until the parallel words equal a known training word.

During the first stage every delay tap is visited in turn. After each step the controller waits for the deserializer to settle. A tap is accepted only if the sampled word stays unchanged for a long run of consecutive samples. When all taps have been visited, the controller picks the centre of the longest run of accepted taps. It resets the delay line and steps it forward to that tap. In the second stage it compares the word with the training word and issues bit-slip pulses. There are at most six boundary positions, and the controller waits between pulses. The result is reported on a done output or an error output. A start pulse begins a fresh calibration at any time.

Top module: `link_align_ctrl`

## Requirements
- R1: While reset is asserted, and after reset until the first start, the outputs dly_rst, dly_inc, bit_slip, done and err are all 0.
- R2: A start pulse is accepted in any state. In the following cycle dly_rst is 1 and done and err are 0, and calibration begins again from tap 0.
- R3: After each delay change the controller waits SETTLE cycles, then compares each sampled word with the word of the previous cycle. A tap is accepted only after STABLE_CNT consecutive equal comparisons. A single difference rejects the tap.
- R4: The scan visits every tap from 0 to NTAPS-1, using one dly_inc pulse per step.
- R5: The chosen tap is first + (len-1)/2, rounded down, where first and len describe the longest run of adjacent accepted taps. If two runs have the same length, the run with the lower taps wins. The controller reaches the chosen tap by one dly_rst pulse followed by exactly that number of dly_inc pulses.
- R6: If no tap is accepted, err rises, done stays 0, and no bit_slip pulse is issued.
- R7: Consecutive bit_slip pulses are separated by more than SETTLE cycles. The word is sampled only after SETTLE idle cycles.
- R8: When the word equals TRAIN (default 6'b100110, bit 5 first), done rises. The number of bit_slip pulses issued is the number of one-position slips needed to reach that boundary, which is at most NSLIP-1.
- R9: If none of the NSLIP boundary positions gives TRAIN, err rises after exactly NSLIP-1 bit_slip pulses.
- R10: done and err are never 1 together. Each holds its value until the next start.
- R11: At most one of dly_rst, dly_inc and bit_slip is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins or restarts calibration |
| rx_word | input | W | Parallel word from the deserializer |
| dly_rst | output | 1 | Returns the input delay to tap 0 |
| dly_inc | output | 1 | Advances the input delay by one tap |
| bit_slip | output | 1 | Moves the word boundary by one bit |
| done | output | 1 | Link aligned |
| err | output | 1 | Calibration failed |

## Verification
Two events can fall on the same clock edge: a start pulse, and a stage decision such as a tap verdict, a delay step or a slip. The bench raises start in the middle of a delay scan. The restart must win that cycle: dly_rst must appear on the next cycle with both status outputs low. The run that follows must then reach the same tap and boundary as an undisturbed run. The bench also sweeps every accepted-tap pattern of an eight-tap line. It combines each pattern with a rotating starting boundary, and computes the expected tap and slip count arithmetically.

// File: rtl/link_align_ctrl.sv
module link_align_ctrl #(
  parameter int W = 6,
  parameter int NTAPS = 32,
  parameter int STABLE_CNT = 4096,
  parameter int SETTLE = 3,
  parameter int NSLIP = 6,
  parameter logic [W-1:0] TRAIN = 6'b100110
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] rx_word,
  output logic         dly_rst,
  output logic         dly_inc,
  output logic         bit_slip,
  output logic         done,
  output logic         err
);
  localparam int TW = $clog2(NTAPS);
  localparam int CW = $clog2(STABLE_CNT);
  localparam int WW = $clog2(SETTLE + 1);
  localparam int SW = $clog2(NSLIP);

  typedef enum logic [3:0] {
    S_IDLE, S_SETTLE, S_MEAS, S_PICK, S_MOVE, S_SWAIT, S_CHECK, S_DONE, S_ERR
  } state_t;

  state_t        state;
  logic [W-1:0]  prev_word;
  logic [TW-1:0] tap, best_start, pick_tap, run_first;
  logic [TW:0]   run_len, best_len, new_run;
  logic [CW-1:0] cnt;
  logic [WW-1:0] wcnt;
  logic [SW-1:0] slip_n;
  logic          same, tap_last, meas_end, settle_end;

  assign same       = rx_word == prev_word;
  assign tap_last   = tap == TW'(NTAPS - 1);
  assign new_run    = run_len + 1'b1;
  assign run_first  = TW'({1'b0, tap} + 1'b1 - new_run);
  assign pick_tap   = TW'({1'b0, best_start} + ((best_len - 1'b1) >> 1));
  assign meas_end   = !same || cnt == CW'(STABLE_CNT - 1);
  assign settle_end = wcnt == WW'(SETTLE - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      prev_word  <= '0;
      tap        <= '0;
      best_start <= '0;
      run_len    <= '0;
      best_len   <= '0;
      cnt        <= '0;
      wcnt       <= '0;
      slip_n     <= '0;
      dly_rst    <= 1'b0;
      dly_inc    <= 1'b0;
      bit_slip   <= 1'b0;
      done       <= 1'b0;
      err        <= 1'b0;
    end else begin
      dly_rst   <= 1'b0;
      dly_inc   <= 1'b0;
      bit_slip  <= 1'b0;
      prev_word <= rx_word;
      if (start) begin
        dly_rst    <= 1'b1;
        done       <= 1'b0;
        err        <= 1'b0;
        tap        <= '0;
        run_len    <= '0;
        best_len   <= '0;
        best_start <= '0;
        wcnt       <= '0;
        state      <= S_SETTLE;
      end else begin
        case (state)
          S_SETTLE: begin
            cnt <= '0;
            if (settle_end) state <= S_MEAS;
            else wcnt <= wcnt + 1'b1;
          end
          S_MEAS: begin
            if (meas_end) begin
              if (same) begin
                run_len <= new_run;
                if (new_run > best_len) begin
                  best_len   <= new_run;
                  best_start <= run_first;
                end
              end else begin
                run_len <= '0;
              end
              wcnt <= '0;
              if (tap_last) begin
                state <= S_PICK;
              end else begin
                dly_inc <= 1'b1;
                tap     <= tap + 1'b1;
                state   <= S_SETTLE;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_PICK: begin
            if (best_len == '0) begin
              err   <= 1'b1;
              state <= S_ERR;
            end else begin
              dly_rst <= 1'b1;
              tap     <= '0;
              state   <= S_MOVE;
            end
          end
          S_MOVE: begin
            if (tap == pick_tap) begin
              wcnt   <= '0;
              slip_n <= '0;
              state  <= S_SWAIT;
            end else begin
              dly_inc <= 1'b1;
              tap     <= tap + 1'b1;
            end
          end
          S_SWAIT: begin
            if (settle_end) state <= S_CHECK;
            else wcnt <= wcnt + 1'b1;
          end
          S_CHECK: begin
            if (rx_word == TRAIN) begin
              done  <= 1'b1;
              state <= S_DONE;
            end else if (slip_n == SW'(NSLIP - 1)) begin
              err   <= 1'b1;
              state <= S_ERR;
            end else begin
              bit_slip <= 1'b1;
              slip_n   <= slip_n + 1'b1;
              wcnt     <= '0;
              state    <= S_SWAIT;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

module link_align_ctrl_chk #(
  parameter int SETTLE = 3
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic dly_rst,
  input logic dly_inc,
  input logic bit_slip,
  input logic done,
  input logic err
);
  logic [7:0] gap;
  logic       seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (bit_slip) begin
      gap  <= 8'd1;
      seen <= 1'b1;
    end else if (gap != 8'hff) begin
      gap <= gap + 1'b1;
    end
  end

  a_r11_one_ctrl_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dly_rst, dly_inc, bit_slip}));
  a_r10_status_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));
  a_r10_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done);
  a_r10_err_holds: assert property (@(posedge clk) disable iff (!rst_n)
    err && !start |=> err);
  a_r2_restart: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> dly_rst && !done && !err);
  a_r7_slip_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    bit_slip && seen |-> gap > SETTLE);
endmodule

bind link_align_ctrl link_align_ctrl_chk #(.SETTLE(SETTLE)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .dly_rst(dly_rst),
  .dly_inc(dly_inc), .bit_slip(bit_slip), .done(done), .err(err)
);

// File: tb/link_align_ctrl_tb.sv
module link_align_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 8;
  localparam logic [5:0] TRAIN = 6'b100110;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [5:0] rx_word = '0;
  logic dly_rst, dly_inc, bit_slip, done, err;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int mtap = 0, mslip = 0, nrst = 0, nslips = 0, noise = 0;
  logic [7:0] cfg_mask = '0, cfg_marg = '0;
  int cfg_off = 0;
  bit cfg_nopat = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  link_align_ctrl #(.W(6), .NTAPS(NT), .STABLE_CNT(16), .SETTLE(3), .NSLIP(6), .TRAIN(TRAIN)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .rx_word(rx_word),
    .dly_rst(dly_rst), .dly_inc(dly_inc), .bit_slip(bit_slip), .done(done), .err(err)
  );

  function automatic logic [5:0] rotl(input logic [5:0] x, input int k);
    logic [5:0] r = x;
    for (int i = 0; i < k; i++) r = {r[4:0], r[5]};
    return r;
  endfunction

  // delay line, deserializer and link model
  always @(negedge clk) begin
    logic [5:0] w;
    if (!rst_n) begin
      mtap = 0;
      mslip = 0;
    end else begin
      if (dly_rst) begin mtap = 0; nrst++; end
      else if (dly_inc && mtap < NT - 1) mtap++;
      if (bit_slip) begin mslip = (mslip + 1) % 6; nslips++; end
    end
    noise++;
    if (cfg_mask[mtap[2:0]]) begin
      w = cfg_nopat ? 6'b000000 : rotl(TRAIN, (cfg_off + mslip) % 6);
      if (cfg_marg[mtap[2:0]] && noise % 10 == 0) w = w ^ 6'b000001;
    end else begin
      w = noise[5:0];
    end
    rx_word = w;
  end

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual cycles %0d expected below 190000", cyc);
      report();
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(posedge clk); #1 start = 1'b1;
    nrst = 0;
    nslips = 0;
    @(posedge clk); #1 start = 1'b0;
  endtask

  task automatic wait_end();
    for (int i = 0; i < 3000; i++) begin
      if (done || err) break;
      @(posedge clk); #1;
    end
  endtask

  task automatic longest(input logic [7:0] good, output int first, output int len);
    int cur = 0;
    first = 0;
    len = 0;
    for (int i = 0; i < NT; i++) begin
      cur = good[i] ? cur + 1 : 0;
      if (cur > len) begin len = cur; first = i - cur + 1; end
    end
  endtask

  task automatic run_case(input logic [7:0] mask, input logic [7:0] marg, input int off, input bit nopat);
    int first, len, s0, exp_sl;
    cfg_mask = mask;
    cfg_marg = marg;
    cfg_off = off;
    cfg_nopat = nopat;
    s0 = mslip;
    pulse_start();
    wait_end();
    longest(mask & ~marg, first, len);
    if (len == 0) begin
      chk(err && !done, "R6 err without good tap", {30'd0, done, err}, 1);
      chk(nslips == 0, "R6 no slips", nslips, 0);
      chk(nrst == 1, "R4 single delay reset", nrst, 1);
    end else begin
      chk(mtap == first + (len - 1) / 2, "R5 chosen tap", mtap, first + (len - 1) / 2);
      chk(nrst == 2, "R5 delay reset before move", nrst, 2);
      if (nopat) begin
        chk(err && !done, "R9 err with no matching boundary", {30'd0, done, err}, 1);
        chk(nslips == 5, "R9 slip count", nslips, 5);
      end else begin
        exp_sl = (6 - (off + s0) % 6) % 6;
        chk(done && !err, "R8 done on match", {30'd0, done, err}, 2);
        chk(nslips == exp_sl, "R8 slip count", nslips, exp_sl);
      end
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk({dly_rst, dly_inc, bit_slip, done, err} == 5'b0, "R1 reset outputs",
        {27'd0, dly_rst, dly_inc, bit_slip, done, err}, 0);
    rst_n = 1'b1;
    repeat (5) @(posedge clk);
    #1;
    chk({dly_rst, dly_inc, bit_slip, done, err} == 5'b0, "R1 idle after reset",
        {27'd0, dly_rst, dly_inc, bit_slip, done, err}, 0);

    // R4 R5 R6 R8: every accepted-tap pattern, rotating starting boundary
    for (int m = 0; m < 256; m++) run_case(m[7:0], 8'h00, m % 6, 1'b0);

    // R3: taps 1,2 glitch once per ten samples and must be rejected
    run_case(8'b0111_1110, 8'b0000_0110, 3, 1'b0);

    // R9: stable link, no boundary gives the training word
    run_case(8'b0001_1100, 8'h00, 0, 1'b1);

    // R10: done holds while idle
    run_case(8'b0011_1000, 8'h00, 1, 1'b0);
    repeat (30) @(posedge clk);
    #1;
    chk(done && !err, "R10 done held", {30'd0, done, err}, 2);

    // R2: restart lands in the middle of the scan
    cfg_mask = 8'hF0;
    cfg_marg = 8'h00;
    cfg_off = 2;
    cfg_nopat = 1'b0;
    pulse_start();
    repeat (40) @(posedge clk);
    #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    chk(dly_rst && !done && !err, "R2 restart pulse", {29'd0, dly_rst, done, err}, 4);
    nrst = 0;
    wait_end();
    chk(done && mtap == 5, "R2 restart result tap", mtap, 5);
    chk(nrst == 2, "R2 restart scan completed again", nrst, 2);

    report();
  end
endmodule